// File: doc/BRIEF.md
# Converter start-up and brown-out sequencer

This block decides, clock by clock, whether a switching power converter may drive its power switch. It watches four conditions: a supply-good bit from the undervoltage comparator, an input-ok bit from the brown-out comparator, a protection latch, and a soft-start-finished bit. From them it produces three controls: a hold that keeps the soft-start capacitor discharged, the switching enable, and a run flag that marks the end of soft-start. It also produces the enable for the current sink that gives the brown-out comparator its hysteresis.

When the supply first becomes good, some product variants wait a fixed number of cycles before soft-start is released. This gives an upstream stage time to settle. The other variants release soft-start on the next clock. Whenever the monitored input falls below its threshold, switching stops in the same cycle. This also happens when an external transistor pulls the monitor pin low. When the input recovers, a fresh soft-start begins and the start-up wait is skipped. A protection trip parks the sequencer until the input drops out or the supply is lost. The analog thresholds sit outside the block, and only their comparator outputs enter it.

Top module: `startup_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, ss_hold is 1, sw_en is 0 and run is 0.
- R2: A variant code v counts as delayed when bit v of DELAY_VARIANTS is 1. With the default, codes 0, 1 and 2 are delayed. When supply_ok rises and a delayed code is present, ss_hold stays 1 for exactly DELAY_CYCLES+1 cycles, counting the cycle in which supply_ok first reads 1. Soft-start is then released, provided bo_ok is 1.
- R3: When supply_ok rises with a non-delayed variant code (default 3 to 7) and bo_ok is 1, ss_hold is 1 only in the cycle in which supply_ok first reads 1, and is 0 from the following cycle.
- R4: During soft-start, run stays 0 until ss_done is sampled 1 at a clock edge. From the next cycle, run is 1 and ss_hold stays 0.
- R5: sw_en is 1 only while soft-start or run is active, supply_ok and bo_ok are 1 and fault is 0. A low bo_ok clears sw_en in the same cycle, and ss_hold becomes 1 from the next cycle.
- R6: Soft-start is released on the first clock edge at which bo_ok reads 1 after a brown-out. This holds for delayed variants too, and also when the start-up wait ended while bo_ok was 0.
- R7: A fault sampled during soft-start or run clears sw_en in the same cycle and enters a fault state. In that state ss_hold is 1 and sw_en is 0, even after the fault input returns to 0.
- R8: The fault state is left only when bo_ok reads 0, which leads to a brown-out wait, or when supply_ok reads 0.
- R9: A low supply_ok clears sw_en in the same cycle and returns the block to its off state at the next edge, from any state. The wait counter restarts, so a new power-up waits the full DELAY_CYCLES again.
- R10: hyst_en equals the inverse of bo_ok in every cycle.
- R11: The variant code is read only at the edge that leaves the off state. Changing it during the wait does not change the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above turn-on level (undervoltage comparator) |
| bo_ok | input | 1 | Monitored input above brown-out threshold and not pulled down |
| fault | input | 1 | Protection latch output |
| ss_done | input | 1 | Soft-start ramp has reached completion |
| variant | input | 3 | Product variant code |
| ss_hold | output | 1 | Keep soft-start discharged |
| sw_en | output | 1 | Switching permitted |
| run | output | 1 | Soft-start finished, steady operation |
| hyst_en | output | 1 | Enable the brown-out hysteresis current sink |

## Verification
The bench builds the block with DELAY_CYCLES set to 20 and keeps the default variant mask. With that setting the full start-up wait, its exact length, and its expiry while bo_ok is low can all be run many times within a short simulation. A behavioural model with its own counter is compared against every output on every cycle. Directed sequences measure the hold length for delayed and non-delayed codes, a variant change during the wait, and exits from the fault state.

// File: rtl/startup_seq.sv
module startup_seq #(
  parameter int unsigned DELAY_CYCLES   = 6_000_000,
  parameter logic [7:0]  DELAY_VARIANTS = 8'b0000_0111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       bo_ok,
  input  logic       fault,
  input  logic       ss_done,
  input  logic [2:0] variant,
  output logic       ss_hold,
  output logic       sw_en,
  output logic       run,
  output logic       hyst_en
);
  localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  typedef enum logic [2:0] {S_OFF, S_WAIT, S_SOFT, S_RUN, S_BROWN, S_TRIP} st_t;

  st_t st, st_nx;
  logic [CNT_W-1:0] cnt;
  logic delayed, active;

  assign delayed = DELAY_VARIANTS[variant];
  assign active  = (st == S_SOFT) || (st == S_RUN);

  always_comb begin
    st_nx = st;
    if (!supply_ok) st_nx = S_OFF;
    else case (st)
      S_OFF:   st_nx = delayed ? S_WAIT : (bo_ok ? S_SOFT : S_BROWN);
      S_WAIT:  if (cnt == LAST) st_nx = bo_ok ? S_SOFT : S_BROWN;
      S_SOFT:  if (!bo_ok) st_nx = S_BROWN;
               else if (fault) st_nx = S_TRIP;
               else if (ss_done) st_nx = S_RUN;
      S_RUN:   if (!bo_ok) st_nx = S_BROWN;
               else if (fault) st_nx = S_TRIP;
      S_BROWN: if (bo_ok) st_nx = S_SOFT;
      S_TRIP:  if (!bo_ok) st_nx = S_BROWN;
      default: st_nx = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (st == S_WAIT && st_nx == S_WAIT) cnt <= cnt + 1'b1;
      else cnt <= '0;
    end
  end

  assign ss_hold = !active;
  assign sw_en   = active && supply_ok && bo_ok && !fault;
  assign run     = (st == S_RUN);
  assign hyst_en = !bo_ok;

  // R9
  supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (st == S_OFF && cnt == '0));
  // R5
  brownout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !bo_ok) |=> ss_hold);
  // R6
  brown_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BROWN && supply_ok && bo_ok) |=> (st == S_SOFT));
  // R8
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRIP && supply_ok && bo_ok) |=> (st == S_TRIP && !sw_en));
  // R2
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (cnt <= LAST));
  // R4
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(ss_done));
endmodule

// File: tb/tb_startup_seq.sv
module tb_startup_seq;
  localparam int D = 20;
  logic clk = 0, rst_n = 0;
  logic supply_ok = 0, bo_ok = 0, fault = 0, ss_done = 0;
  logic [2:0] variant = 0;
  logic ss_hold, sw_en, run, hyst_en;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  startup_seq #(.DELAY_CYCLES(D)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .bo_ok(bo_ok),
    .fault(fault), .ss_done(ss_done), .variant(variant),
    .ss_hold(ss_hold), .sw_en(sw_en), .run(run), .hyst_en(hyst_en));

  // reference model: 0 off, 1 wait, 2 soft, 3 run, 4 brown, 5 trip
  int m_st = 0, m_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_st = 0; m_cnt = 0; end
    else if (!supply_ok) begin m_st = 0; m_cnt = 0; end
    else begin
      case (m_st)
        0: begin m_cnt = 0; m_st = (variant <= 2) ? 1 : (bo_ok ? 2 : 4); end
        1: if (m_cnt == D - 1) begin m_cnt = 0; m_st = bo_ok ? 2 : 4; end
           else m_cnt++;
        2: m_st = !bo_ok ? 4 : fault ? 5 : ss_done ? 3 : 2;
        3: m_st = !bo_ok ? 4 : fault ? 5 : 3;
        4: if (bo_ok) m_st = 2;
        5: if (!bo_ok) m_st = 4;
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #8;
    if (rst_n && !finished) begin
      automatic bit act = (m_st == 2 || m_st == 3);
      chk(ss_hold == !act, "R2 ss_hold model", ss_hold, !act);
      chk(sw_en == (act && supply_ok && bo_ok && !fault), "R5 sw_en model",
          sw_en, act && supply_ok && bo_ok && !fault);
      chk(run == (m_st == 3), "R4 run model", run, m_st == 3);
      chk(hyst_en == !bo_ok, "R10 hyst_en", hyst_en, !bo_ok);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_hold(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      #8;
      if (!ss_hold) break;
      n++;
      @(negedge clk);
    end
  endtask

  int n;

  initial begin
    #100000000;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    #8 chk(ss_hold && !sw_en && !run, "R1 reset", {ss_hold, sw_en, run}, 3'b100);
    @(negedge clk) rst_n = 1;
    #8 chk(ss_hold && !sw_en && !run, "R1 after reset", {ss_hold, sw_en, run}, 3'b100);

    @(negedge clk); variant = 0; bo_ok = 1; supply_ok = 1;
    count_hold(n); chk(n == D + 1, "R2 delayed variant 0", n, D + 1);
    #2 chk(sw_en && !run, "R5 soft-start switching", {sw_en, run}, 2'b10);
    step(3); ss_done = 1; @(negedge clk); ss_done = 0;
    #8 chk(run && !ss_hold, "R4 run after done", {run, ss_hold}, 2'b10);

    @(negedge clk); bo_ok = 0;
    #2 chk(!sw_en && hyst_en, "R5 immediate stop", {sw_en, hyst_en}, 2'b01);
    @(negedge clk); #2 chk(ss_hold && !run, "R5 hold next cycle", {ss_hold, run}, 2'b10);
    step(3); bo_ok = 1;
    count_hold(n); chk(n == 1, "R6 recovery no wait", n, 1);

    step(2); fault = 1;
    #2 chk(!sw_en, "R7 fault immediate", sw_en, 0);
    @(negedge clk); fault = 0; step(4);
    #8 chk(ss_hold && !sw_en, "R7 trip sticky", {ss_hold, sw_en}, 2'b10);
    bo_ok = 0; step(2); bo_ok = 1;
    count_hold(n); chk(n == 1, "R8 trip left by brown-out", n, 1);

    step(2); fault = 1; @(negedge clk); fault = 0;
    supply_ok = 0;
    #2 chk(!sw_en, "R9 supply loss immediate", sw_en, 0);
    step(3); variant = 1; supply_ok = 1;
    count_hold(n); chk(n == D + 1, "R9 full wait after supply loss", n, D + 1);

    step(5); supply_ok = 0; step(2); variant = 3; supply_ok = 1;
    count_hold(n); chk(n == 1, "R3 non-delayed variant 3", n, 1);
    step(2); supply_ok = 0; step(2); variant = 7; supply_ok = 1;
    count_hold(n); chk(n == 1, "R3 non-delayed variant 7", n, 1);

    step(2); supply_ok = 0; step(2); variant = 2; supply_ok = 1;
    step(5); variant = 4;
    count_hold(n); chk(n == D + 1 - 5, "R11 variant change ignored", n, D - 4);

    step(2); supply_ok = 0; step(2); variant = 0; bo_ok = 0; supply_ok = 1;
    step(D + 6);
    #8 chk(ss_hold, "R6 wait expired during brown-out", ss_hold, 1);
    @(negedge clk); bo_ok = 1;
    count_hold(n); chk(n == 1, "R6 release after late recovery", n, 1);

    step(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule